// File: doc/BRIEF.md
# Timestamped Frame Playback Scheduler

This block replays pre-computed 32-bit test frames at times the host chooses. The host writes each entry over a valid/ready port. An entry pairs a timestamp with a frame. Entries wait in a small internal FIFO. A free-running time base counts ticks that each span a fixed number of clock cycles. The head entry leaves when the time base reaches its timestamp. The frame then goes out on a serial line, one bit after another.

A frame lasts exactly `TICKS_PER_FRAME` ticks. When timestamps are spaced by that amount, frames leave back to back with no idle cycle between them. Timing depends only on the timestamps and not on when the host delivers the data. Delivery only has to stay ahead of the schedule. When delivery falls behind, the block reports it through two sticky flags:

- a late flag, set when an entry is sent after its tick has already passed;
- an underflow flag, set when the line runs dry because the FIFO is empty.

A synchronous start pulse zeroes the time base and clears both flags. The schedule runs from the cycle after that pulse.

Top module: `frame_playback_sched`

## Requirements
- R1: A launched frame is sent on `serOut` most significant bit first, so the header (`wrFrame[31:16]`) goes before the payload (`wrFrame[15:0]`). Each bit is held for `FRAME_W`-th of the frame time, which is 5 clock cycles when `CLKS_PER_UNIT`=1. `serActive` is high for exactly those 160 cycles. `serOut` is low whenever `serActive` is low.
- R2: After start, the time base advances by one every tick. A tick is 16·`CLKS_PER_UNIT` cycles, so that `TICKS_PER_FRAME` (10) ticks equal one frame time. The time base is `TIME_W` (34) bits wide.
- R3: With the serializer free, the head entry launches in the first cycle in which the time base equals its timestamp. The first bit of that frame appears on `serOut`, with `serActive` high, in the following cycle.
- R4: Two entries whose timestamps differ by exactly `TICKS_PER_FRAME` produce contiguous frames. The second frame's first bit follows the first frame's last bit with no gap.
- R5: Entries are sent strictly in write order. A write is taken only in a cycle with `wrValid` and `wrReady` both high. `wrReady` is low while the FIFO holds `FIFO_DEPTH` entries, and a write offered while full is dropped.
- R6: When the head entry becomes eligible after the time base has passed its timestamp, it launches in the first cycle the serializer is free. The sticky `late` flag is then set.
- R7: When the serializer ends a frame while the FIFO is empty, `underflow` is set and stays set, and the line returns to idle.
- R8: Nothing launches and the time base does not count until the first start pulse. A start pulse zeroes the time base and clears `late` and `underflow`. Scheduling runs from the next cycle, with the time base at 0 for one whole tick.
- R9: `fifoLevel` equals the number of entries held. It rises by one for each accepted write and falls by one for each launch.
- R10: After reset, `wrReady` is 1, and `fifoLevel`, `late`, `underflow`, `serOut` and `serActive` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Synchronous start: zero the time base, clear flags, begin scheduling |
| wrValid | input | 1 | Host offers an entry |
| wrReady | output | 1 | FIFO can take an entry |
| wrTime | input | TIME_W | Launch timestamp in ticks |
| wrFrame | input | FRAME_W | Frame: header in the upper half, payload in the lower half |
| serOut | output | 1 | Serial frame data, low when idle |
| serActive | output | 1 | High while a frame bit is on `serOut` |
| fifoLevel | output | $clog2(FIFO_DEPTH+1) | Entries currently held |
| late | output | 1 | Sticky: an entry left after its tick |
| underflow | output | 1 | Sticky: the serializer finished with the FIFO empty |

## Verification
Some properties are checked by assertions on every cycle:
- the flags stay set until the next start, and a start leaves both flags clear with the time base at zero;
- the time base never steps backward while counting;
- the FIFO level stays in range and moves by at most one per cycle;
- a launch never takes from an empty FIFO;
- a frame, once begun, is never cut short.

Other behaviour can only be shown by the bench's scenarios:
- the exact cycle at which each frame starts, as a function of its timestamp and of the frame before it;
- the bit order on the line;
- the seamless joins between back-to-back frames;
- which mixtures of spacing make an entry late.

// File: rtl/fps_pkg.sv
package fps_pkg;

  // Strobes from control to datapath.
  typedef struct packed {
    logic clearTime;  // zero the time base and its prescaler
    logic countEn;    // let the time base advance
    logic launch;     // pop the head entry into the serializer
  } fpsStrobe_t;

  function automatic int gcdOf(input int a, input int b);
    int x;
    int y;
    int t;
    x = a;
    y = b;
    while (y != 0) begin
      t = x % y;
      x = y;
      y = t;
    end
    return x;
  endfunction

endpackage

// File: rtl/fps_datapath.sv
module fps_datapath
  import fps_pkg::*;
#(
  parameter int TIME_W    = 34,
  parameter int FRAME_W   = 32,
  parameter int DEPTH     = 8,
  parameter int TICK_CLKS = 16,
  parameter int BIT_CLKS  = 5
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  fpsStrobe_t                   ctl,
  input  logic                         wrValid,
  output logic                         wrReady,
  input  logic [TIME_W-1:0]            wrTime,
  input  logic [FRAME_W-1:0]           wrFrame,
  output logic [TIME_W-1:0]            tbNow,
  output logic [TIME_W-1:0]            headTime,
  output logic                         fifoEmpty,
  output logic [$clog2(DEPTH+1)-1:0]   fifoLevel,
  output logic                         serBusy,
  output logic                         serLast,
  output logic                         serOut,
  output logic                         serActive
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = (TICK_CLKS > 1) ? $clog2(TICK_CLKS) : 1;
  localparam int BW = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;
  localparam int IW = $clog2(FRAME_W);

  // ---------------- time base ----------------
  logic [PW-1:0]     preCnt;
  logic [TIME_W-1:0] tbCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      tbCnt  <= '0;
    end else if (ctl.clearTime) begin
      preCnt <= '0;
      tbCnt  <= '0;
    end else if (ctl.countEn) begin
      if (preCnt == PW'(TICK_CLKS - 1)) begin
        preCnt <= '0;
        tbCnt  <= tbCnt + 1'b1;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  assign tbNow = tbCnt;

  // ---------------- entry FIFO ----------------
  logic [TIME_W-1:0]  memTime  [DEPTH];
  logic [FRAME_W-1:0] memFrame [DEPTH];
  logic [AW-1:0]      wrPtr;
  logic [AW-1:0]      rdPtr;
  logic [CW-1:0]      count;
  logic               push;
  logic               pop;

  assign wrReady   = (count != CW'(DEPTH));
  assign push      = wrValid && wrReady;
  assign pop       = ctl.launch;
  assign fifoEmpty = (count == '0);
  assign fifoLevel = count;
  assign headTime  = memTime[rdPtr];

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) begin
      memTime[wrPtr]  <= wrTime;
      memFrame[wrPtr] <= wrFrame;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // ---------------- serializer ----------------
  logic [FRAME_W-1:0] shiftReg;
  logic [IW-1:0]      bitIdx;
  logic [BW-1:0]      clkCnt;
  logic               busy;
  logic               bitEnd;

  assign bitEnd  = (clkCnt == BW'(BIT_CLKS - 1));
  assign serLast = busy && bitEnd && (bitIdx == IW'(FRAME_W - 1));
  assign serBusy = busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitIdx   <= '0;
      clkCnt   <= '0;
      busy     <= 1'b0;
    end else if (ctl.launch) begin
      shiftReg <= memFrame[rdPtr];
      bitIdx   <= '0;
      clkCnt   <= '0;
      busy     <= 1'b1;
    end else if (busy) begin
      if (bitEnd) begin
        clkCnt <= '0;
        if (bitIdx == IW'(FRAME_W - 1)) begin
          busy <= 1'b0;
        end else begin
          bitIdx   <= bitIdx + 1'b1;
          shiftReg <= {shiftReg[FRAME_W-2:0], 1'b0};
        end
      end else begin
        clkCnt <= clkCnt + 1'b1;
      end
    end
  end

  assign serOut    = busy && shiftReg[FRAME_W-1];
  assign serActive = busy;

  // ---------------- assertions ----------------
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH)); // R9

  AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (count == $past(count)) || (count == $past(count) + 1'b1) ||
             ($past(count) == count + 1'b1)); // R9

  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rstN)
    ctl.launch |-> (count != '0)); // R5

  AST_TIME_MONOTONIC: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.countEn && !ctl.clearTime) |=> (tbCnt >= $past(tbCnt))); // R2

  AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !serLast) |=> busy); // R1

endmodule

// File: rtl/fps_control.sv
module fps_control
  import fps_pkg::*;
#(
  parameter int TIME_W = 34
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [TIME_W-1:0] tbNow,
  input  logic [TIME_W-1:0] headTime,
  input  logic              fifoEmpty,
  input  logic              serBusy,
  input  logic              serLast,
  output fpsStrobe_t        ctl,
  output logic              late,
  output logic              underflow
);

  logic running;
  logic serFree;
  logic due;

  assign serFree = !serBusy || serLast;
  assign due     = (tbNow >= headTime);

  always_comb begin
    ctl.clearTime = start;
    ctl.countEn   = running && !start;
    ctl.launch    = running && !start && !fifoEmpty && serFree && due;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running   <= 1'b0;
      late      <= 1'b0;
      underflow <= 1'b0;
    end else if (start) begin
      running   <= 1'b1;
      late      <= 1'b0;
      underflow <= 1'b0;
    end else begin
      if (ctl.launch && (tbNow > headTime)) late <= 1'b1;
      if (serLast && fifoEmpty)             underflow <= 1'b1;
    end
  end

  AST_LATE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (late && !start) |=> late); // R6

  AST_UNDERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (underflow && !start) |=> underflow); // R7

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (!late && !underflow && (tbNow == '0))); // R8

endmodule

// File: rtl/frame_playback_sched.sv
module frame_playback_sched
  import fps_pkg::*;
#(
  parameter int TIME_W          = 34,
  parameter int FRAME_W         = 32,
  parameter int TICKS_PER_FRAME = 10,
  parameter int CLKS_PER_UNIT   = 78,
  parameter int FIFO_DEPTH      = 8
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             start,
  input  logic                             wrValid,
  output logic                             wrReady,
  input  logic [TIME_W-1:0]                wrTime,
  input  logic [FRAME_W-1:0]               wrFrame,
  output logic                             serOut,
  output logic                             serActive,
  output logic [$clog2(FIFO_DEPTH+1)-1:0]  fifoLevel,
  output logic                             late,
  output logic                             underflow
);

  // A frame is FRAME_W bits and also TICKS_PER_FRAME ticks; split it into
  // the smallest common unit so both bit and tick are whole clock counts.
  localparam int G         = gcdOf(FRAME_W, TICKS_PER_FRAME);
  localparam int BIT_CLKS  = (TICKS_PER_FRAME / G) * CLKS_PER_UNIT;
  localparam int TICK_CLKS = (FRAME_W / G) * CLKS_PER_UNIT;

  fpsStrobe_t        ctl;
  logic [TIME_W-1:0] tbNow;
  logic [TIME_W-1:0] headTime;
  logic              fifoEmpty;
  logic              serBusy;
  logic              serLast;

  fps_control #(
    .TIME_W (TIME_W)
  ) i_control (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .tbNow     (tbNow),
    .headTime  (headTime),
    .fifoEmpty (fifoEmpty),
    .serBusy   (serBusy),
    .serLast   (serLast),
    .ctl       (ctl),
    .late      (late),
    .underflow (underflow)
  );

  fps_datapath #(
    .TIME_W    (TIME_W),
    .FRAME_W   (FRAME_W),
    .DEPTH     (FIFO_DEPTH),
    .TICK_CLKS (TICK_CLKS),
    .BIT_CLKS  (BIT_CLKS)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .wrValid   (wrValid),
    .wrReady   (wrReady),
    .wrTime    (wrTime),
    .wrFrame   (wrFrame),
    .tbNow     (tbNow),
    .headTime  (headTime),
    .fifoEmpty (fifoEmpty),
    .fifoLevel (fifoLevel),
    .serBusy   (serBusy),
    .serLast   (serLast),
    .serOut    (serOut),
    .serActive (serActive)
  );

endmodule

// File: tb/test_frame_playback_sched.sv
module test_frame_playback_sched;

  localparam int TW     = 34;
  localparam int FW     = 32;
  localparam int DEP    = 8;
  localparam int TICK   = 16;
  localparam int BITC   = 5;
  localparam int FRAMEC = 160;
  localparam int TPF    = 10;
  localparam int CAPN   = 128;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic          wrValid = 1'b0;
  logic [TW-1:0] wrTime = '0;
  logic [FW-1:0] wrFrame = '0;
  logic          wrReady;
  logic          serOut;
  logic          serActive;
  logic [3:0]    fifoLevel;
  logic          late;
  logic          underflow;

  frame_playback_sched #(
    .TIME_W(TW), .FRAME_W(FW), .TICKS_PER_FRAME(TPF),
    .CLKS_PER_UNIT(1), .FIFO_DEPTH(DEP)
  ) i_frame_playback_sched (
    .clk(clk), .rstN(rstN), .start(start),
    .wrValid(wrValid), .wrReady(wrReady), .wrTime(wrTime), .wrFrame(wrFrame),
    .serOut(serOut), .serActive(serActive), .fifoLevel(fifoLevel),
    .late(late), .underflow(underflow)
  );

  always #4 clk = ~clk;  // 125 MHz

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- line monitor ----------------
  int         capCount = 0;
  int         capStart [CAPN];
  logic [31:0] capData [CAPN];
  logic       prevAct = 1'b0;
  int         actStart = 0;
  int         aIdx = 0;
  logic [31:0] shiftIn = '0;
  int         idleHigh = 0;
  int         lenErr = 0;

  always @(negedge clk) begin
    if (serActive && !prevAct) begin
      actStart = cyc;
      shiftIn  = '0;
    end
    if (serActive) begin
      aIdx = cyc - actStart;
      if (aIdx % BITC == 2) shiftIn = {shiftIn[30:0], serOut};
      if (aIdx == FRAMEC - 1) begin
        if (capCount < CAPN) begin
          capStart[capCount] = actStart;
          capData[capCount]  = shiftIn;
        end
        capCount++;
        actStart = cyc + 1;
        shiftIn  = '0;
      end
    end else begin
      if (serOut) idleHigh++;
      if (prevAct && (cyc != actStart)) lenErr++;
    end
    prevAct = serActive;
  end

  // ---------------- reference functions ----------------
  function automatic int expLaunch(input int s, input int ts, input int prevL, input bit first);
    int e;
    e = s + 1 + TICK * ts;
    if (!first && (prevL + FRAMEC > e)) e = prevL + FRAMEC;
    return e;
  endfunction

  function automatic bit isLate(input int s, input int ts, input int l);
    return ((l - s - 1) / TICK) > ts;
  endfunction

  // ---------------- drivers ----------------
  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic doStart(output int s);
    start = 1'b1;
    s = cyc;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic pushFrame(input int ts, input logic [31:0] d, output int acc);
    wrValid = 1'b1;
    wrTime  = TW'(ts);
    wrFrame = d;
    forever begin
      if (wrReady) begin
        acc = cyc;
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    wrValid = 1'b0;
  endtask

  task automatic waitUntil(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // mode 0: all back-to-back; 1: random mix; 2: overlapping (late)
  task automatic runBatch(input int n, input int mode);
    int ts [DEP];
    logic [31:0] dat [DEP];
    int expS [DEP];
    int s, acc, base, prevL, l, g;
    bit anyLate;
    string rq;
    doReset();
    ts[0] = $urandom % 4;
    for (int i = 0; i < n; i++) begin
      if (i > 0) begin
        case (mode)
          0: g = TPF;
          2: g = 3;
          default: begin
            case ($urandom % 4)
              0: g = TPF;
              1: g = TPF + ($urandom % 6);
              2: g = $urandom % TPF;
              default: g = TPF + 20;
            endcase
          end
        endcase
        ts[i] = ts[i-1] + g;
      end
      dat[i] = $urandom;
      pushFrame(ts[i], dat[i], acc);
    end
    chk(fifoLevel == 4'(n), "R9", "level after load", fifoLevel, n);
    if (n == DEP) begin
      chk(wrReady == 1'b0, "R5", "wrReady when full", wrReady, 0);
      wrValid = 1'b1; wrTime = '0; wrFrame = 32'hDEAD_BEEF;
      repeat (3) @(negedge clk);
      wrValid = 1'b0;
      chk(fifoLevel == 4'(DEP), "R5", "level after write while full", fifoLevel, DEP);
    end
    base = capCount;
    doStart(s);
    prevL = 0;
    anyLate = 1'b0;
    for (int i = 0; i < n; i++) begin
      l = expLaunch(s, ts[i], prevL, i == 0);
      if (isLate(s, ts[i], l)) anyLate = 1'b1;
      expS[i] = l + 1;
      prevL = l;
    end
    waitUntil(expS[n-1] + 10);
    chk(underflow == 1'b0, "R7", "no underflow before last frame ends", underflow, 0);
    waitUntil(expS[n-1] + FRAMEC + 5);
    chk(capCount - base == n, "R3", "frames sent", capCount - base, n);
    rq = (mode == 0) ? "R4" : "R3";
    for (int i = 0; i < n; i++) begin
      chk(capData[base+i] == dat[i], "R1", "frame bits in order", capData[base+i], dat[i]);
      chk(capStart[base+i] == expS[i], rq, "frame start cycle", capStart[base+i], expS[i]);
    end
    chk(late == anyLate, "R6", "late flag", late, anyLate);
    chk(underflow == 1'b1, "R7", "underflow after last frame", underflow, 1);
    chk(serActive == 1'b0 && serOut == 1'b0, "R7", "line idle after underflow",
        {serActive, serOut}, 0);
  endtask

  // ---------------- main ----------------
  initial begin
    int s, acc, base;
    $urandom(1234);
    @(negedge clk);
    chk(fifoLevel == 0 && late == 0 && underflow == 0, "R10", "flags/level in reset",
        {fifoLevel, late, underflow}, 0);
    chk(wrReady == 1'b1 && serOut == 0 && serActive == 0, "R10", "port idle in reset",
        {wrReady, serOut, serActive}, 3'b100);
    doReset();

    // R8: nothing launches before start
    base = capCount;
    pushFrame(0, 32'hA5C3_0F81, acc);
    repeat (60) @(negedge clk);
    chk(capCount == base && serActive == 0, "R8", "no launch before start", capCount - base, 0);
    chk(fifoLevel == 1, "R9", "level with one entry", fifoLevel, 1);
    doStart(s);
    waitUntil(s + 2 + FRAMEC + 5);
    chk(capCount - base == 1, "R3", "single frame sent", capCount - base, 1);
    chk(capStart[base] == s + 2, "R8", "ts 0 launches cycle after start", capStart[base], s + 2);
    chk(capData[base] == 32'hA5C3_0F81, "R1", "header then payload", capData[base], 32'hA5C3_0F81);
    chk(underflow == 1'b1 && late == 1'b0, "R7", "underflow set, not late", {underflow, late}, 2'b10);
    chk(fifoLevel == 0, "R9", "level after launch", fifoLevel, 0);

    // R8: start clears the flags
    doStart(s);
    chk(underflow == 1'b0 && late == 1'b0, "R8", "start clears flags", {underflow, late}, 0);

    // R6: entry written after its tick launches at once
    repeat (50 * TICK) @(negedge clk);
    chk(late == 1'b0, "R6", "late clear before stale entry", late, 0);
    base = capCount;
    pushFrame(5, 32'h1234_8001, acc);
    waitUntil(acc + 2 + FRAMEC + 5);
    chk(capCount - base == 1 && capStart[base] == acc + 2, "R6", "stale entry start",
        capStart[base], acc + 2);
    chk(capData[base] == 32'h1234_8001, "R1", "stale entry bits", capData[base], 32'h1234_8001);
    chk(late == 1'b1, "R6", "late set", late, 1);

    runBatch(DEP, 0);   // R4 back-to-back
    runBatch(DEP, 2);   // R6 overlapping times
    for (int b = 0; b < 4; b++) runBatch(3 + ($urandom % 6), 1);

    chk(idleHigh == 0, "R1", "serOut high while idle", idleHigh, 0);
    chk(lenErr == 0, "R1", "frame length errors", lenErr, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual %0d expected %0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule